// File: doc/BRIEF.md
# Per-Class Receive Buffer Quota Admitter

This block sits at the receive side of a control-processor port and decides, in hardware, whether each incoming packet may take a receive buffer. Every packet carries a class code and the number of the port it came in on. Flooded packets with an unknown destination are charged to a quota that belongs to their ingress port. Spanning-tree control, internal card-to-card commands and management frames are each charged to a quota for their class. One extra shared pool catches packets whose private quota is used up. If neither the private quota nor the shared pool has room, the packet is dropped at once and software never sees it.

Software hands each buffer back with a release event. The event names the counter the packet was charged to, so the hardware counts and the software counts stay in step. Every limit can be rewritten at run time. A per-class count of dropped packets can be read through a select input, so an operator can see which traffic is being shed under overload.

Top module: `quota_admitter`

## Requirements
- R1: The class code decides which counter a packet is charged to. Code 0 is flooded traffic and is charged to the counter of its ingress port. Codes 1, 2 and 3 (spanning tree, internal command, management) are charged to one counter per class. Counter entry numbers: classes 1..3 use entries 0..2, flood ports 0..3 use entries 3..6, and the shared pool is entry 7.
- R2: A header sampled on `hdrValid` at one rising edge shows its decision on `decValid`, `decAdmit` and `decShared` after that edge, and those outputs stay valid until the next edge. `decValid` is low in any cycle that follows one without a header.
- R3: A packet whose private counter is below its limit is admitted with `decShared`=0, and its private counter goes up by one.
- R4: A packet whose private counter is at or above its limit is admitted with `decShared`=1 if the shared pool is below its limit, and the pool counter goes up by one. If the pool is also full, the packet is dropped (`decAdmit`=0, `decShared`=0).
- R5: A release event decrements the shared pool when `relShared`=1, and otherwise decrements the counter that `relClass`/`relPort` select under R1. A release on a counter that is already zero has no effect.
- R6: When one ingress port uses up its flood quota, flooded packets from the other ports are not affected.
- R7: A `cfgWe` pulse sets the limit of entry `cfgIdx` to `cfgLimit`. Headers sampled after that edge use the new limit. If a limit is lowered to or below the current usage, that counter admits nothing until its usage falls below the limit.
- R8: Each class has a drop counter that goes up by one on every drop of that class and saturates at its maximum value. `dropCount` shows the counter picked by `dropSel`, with no added delay.
- R9: After reset every usage counter and every drop counter is zero, every limit equals `DEF_LIMIT`, and `decValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Header fields are valid this cycle |
| hdrClass | input | 2 | Packet class code |
| hdrPort | input | 2 | Ingress port of the packet |
| decValid | output | 1 | Decision valid |
| decAdmit | output | 1 | Packet admitted |
| decShared | output | 1 | Packet charged to the shared pool |
| relValid | input | 1 | Buffer release event |
| relClass | input | 2 | Class of the released buffer |
| relPort | input | 2 | Ingress port of the released buffer |
| relShared | input | 1 | Released buffer had been charged to the shared pool |
| cfgWe | input | 1 | Limit write strobe |
| cfgIdx | input | 3 | Counter entry whose limit is written |
| cfgLimit | input | CNT_W | New limit value |
| dropSel | input | 2 | Class whose drop count is shown |
| dropCount | output | DROP_W | Drop count of the selected class |

## Verification
The bench builds the block with `DEF_LIMIT`=2 and `DROP_W`=4. With those values every private quota and the shared pool fill after two packets, so the path that spills over to the shared pool and the drop path each show up within a few headers. The narrow drop counter reaches saturation after fifteen drops. At the default counter width, lowering a limit below the current usage and then raising it again can be shown with only a handful of releases.

// File: rtl/quota_adm_pkg.sv
package quota_adm_pkg;
  localparam int NumClass  = 4;
  localparam int NumPort   = 4;
  localparam int ClsW      = $clog2(NumClass);
  localparam int PortW     = $clog2(NumPort);
  localparam int FloodBase = NumClass - 1;
  localparam int NumEnt    = NumClass - 1 + NumPort + 1;
  localparam int EntW      = $clog2(NumEnt);
  localparam int SharedIdx = NumEnt - 1;

  typedef logic [EntW-1:0] ent_t;

  // strobes from control to counter datapath
  typedef struct packed {
    logic             chargeEn;
    ent_t             chargeIdx;
    logic             releaseEn;
    ent_t             releaseIdx;
    logic             dropEn;
    logic [ClsW-1:0]  dropCls;
  } strobe_t;

  // flood class (code 0) is charged per ingress port, others per class
  function automatic ent_t entryOf(input logic [ClsW-1:0] cls,
                                   input logic [PortW-1:0] port);
    if (cls == '0) return ent_t'(FloodBase) + ent_t'(port);
    else           return ent_t'(cls) - ent_t'(1);
  endfunction
endpackage

// File: rtl/qa_ctrl.sv
module qa_ctrl
  import quota_adm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hdrValid,
  input  logic [ClsW-1:0]   hdrClass,
  input  logic [PortW-1:0]  hdrPort,
  input  logic              relValid,
  input  logic [ClsW-1:0]   relClass,
  input  logic [PortW-1:0]  relPort,
  input  logic              relShared,
  input  logic [NumEnt-1:0] room,
  output strobe_t           strobes,
  output logic              decValid,
  output logic              decAdmit,
  output logic              decShared
);
  ent_t privIdx;
  logic privOk, sharedOk;

  always_comb begin
    privIdx  = entryOf(hdrClass, hdrPort);
    privOk   = room[privIdx];
    sharedOk = room[SharedIdx];
    strobes.chargeEn   = hdrValid && (privOk || sharedOk);
    strobes.chargeIdx  = privOk ? privIdx : ent_t'(SharedIdx);
    strobes.dropEn     = hdrValid && !privOk && !sharedOk;
    strobes.dropCls    = hdrClass;
    strobes.releaseEn  = relValid;
    strobes.releaseIdx = relShared ? ent_t'(SharedIdx) : entryOf(relClass, relPort);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAdmit  <= 1'b0;
      decShared <= 1'b0;
    end else begin
      decValid  <= hdrValid;
      decAdmit  <= hdrValid && (privOk || sharedOk);
      decShared <= hdrValid && !privOk && sharedOk;
    end
  end

  // R2: decision follows a header by exactly one edge
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> decValid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> !decValid);
  // R4: a shared-pool charge is always an admission
  a_r4_shared_admits: assert property (@(posedge clk) disable iff (!rstN)
    decShared |-> decAdmit);
  // R4: a header is either charged or dropped, never both
  a_r4_drop_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dropEn |-> !strobes.chargeEn);
endmodule

// File: rtl/qa_data.sv
module qa_data
  import quota_adm_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DROP_W    = 8,
  parameter int DEF_LIMIT = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              cfgWe,
  input  ent_t              cfgIdx,
  input  logic [CNT_W-1:0]  cfgLimit,
  input  logic [ClsW-1:0]   dropSel,
  output logic [NumEnt-1:0] room,
  output logic [DROP_W-1:0] dropCount
);
  logic [DROP_W-1:0] dropArr [NumClass];

  for (genvar e = 0; e < NumEnt; e++) begin : g_ent
    logic [CNT_W-1:0] usedQ, limitQ;
    logic inc, dec;
    assign inc = strobes.chargeEn && (strobes.chargeIdx == ent_t'(e));
    assign dec = strobes.releaseEn && (strobes.releaseIdx == ent_t'(e)) && (usedQ != '0);
    assign room[e] = usedQ < limitQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        usedQ  <= '0;
        limitQ <= CNT_W'(DEF_LIMIT);
      end else begin
        usedQ <= usedQ + {{(CNT_W-1){1'b0}}, inc} - {{(CNT_W-1){1'b0}}, dec};
        if (cfgWe && cfgIdx == ent_t'(e)) limitQ <= cfgLimit;
      end
    end

    // R5: a counter at zero never wraps on a release
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
      (usedQ == '0 && !inc) |=> usedQ == '0);
  end

  for (genvar c = 0; c < NumClass; c++) begin : g_drop
    logic [DROP_W-1:0] dropQ;
    always_ff @(posedge clk) begin
      if (!rstN) dropQ <= '0;
      else if (strobes.dropEn && strobes.dropCls == ClsW'(c) && dropQ != '1)
        dropQ <= dropQ + 1'b1;
    end
    assign dropArr[c] = dropQ;

    // R8: a saturated drop counter holds
    a_r8_drop_sat: assert property (@(posedge clk) disable iff (!rstN)
      dropQ == '1 |=> dropQ == '1);
  end

  assign dropCount = dropArr[dropSel];

  // R3: nothing is charged to a counter without room
  a_r3_charge_has_room: assert property (@(posedge clk) disable iff (!rstN)
    strobes.chargeEn |-> room[strobes.chargeIdx]);
endmodule

// File: rtl/quota_admitter.sv
module quota_admitter
  import quota_adm_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DROP_W    = 8,
  parameter int DEF_LIMIT = 4
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hdrValid,
  input  logic [ClsW-1:0]    hdrClass,
  input  logic [PortW-1:0]   hdrPort,
  output logic               decValid,
  output logic               decAdmit,
  output logic               decShared,
  input  logic               relValid,
  input  logic [ClsW-1:0]    relClass,
  input  logic [PortW-1:0]   relPort,
  input  logic               relShared,
  input  logic               cfgWe,
  input  logic [EntW-1:0]    cfgIdx,
  input  logic [CNT_W-1:0]   cfgLimit,
  input  logic [ClsW-1:0]    dropSel,
  output logic [DROP_W-1:0]  dropCount
);
  strobe_t           strobes;
  logic [NumEnt-1:0] room;

  qa_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .hdrValid(hdrValid), .hdrClass(hdrClass), .hdrPort(hdrPort),
    .relValid(relValid), .relClass(relClass), .relPort(relPort), .relShared(relShared),
    .room(room), .strobes(strobes),
    .decValid(decValid), .decAdmit(decAdmit), .decShared(decShared)
  );

  qa_data #(.CNT_W(CNT_W), .DROP_W(DROP_W), .DEF_LIMIT(DEF_LIMIT)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgLimit(cfgLimit),
    .dropSel(dropSel), .room(room), .dropCount(dropCount)
  );
endmodule

// File: tb/quota_admitter_tb_top.sv
module quota_admitter_tb_top;
  localparam int CW = 8;
  localparam int DW = 4;
  localparam int DL = 2;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdrValid = 0, relValid = 0, relShared = 0, cfgWe = 0;
  logic [1:0] hdrClass = 0, hdrPort = 0, relClass = 0, relPort = 0, dropSel = 0;
  logic [2:0] cfgIdx = 0;
  logic [CW-1:0] cfgLimit = 0;
  logic decValid, decAdmit, decShared;
  logic [DW-1:0] dropCount;

  int nChecks = 0, nFails = 0;
  int mUsed [8];
  int mLim  [8];
  int mDrop [4];

  always #10 clk = ~clk;

  quota_admitter #(.CNT_W(CW), .DROP_W(DW), .DEF_LIMIT(DL)) dut_i (
    .clk(clk), .rstN(rstN),
    .hdrValid(hdrValid), .hdrClass(hdrClass), .hdrPort(hdrPort),
    .decValid(decValid), .decAdmit(decAdmit), .decShared(decShared),
    .relValid(relValid), .relClass(relClass), .relPort(relPort), .relShared(relShared),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgLimit(cfgLimit),
    .dropSel(dropSel), .dropCount(dropCount)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int entOf(input int cls, input int port);
    return (cls == 0) ? 3 + port : cls - 1;
  endfunction

  // drive one header, compare against the model
  task automatic hdr(input string req, input int cls, input int port);
    int e = entOf(cls, port);
    int expA, expS;
    hdrValid = 1; hdrClass = 2'(cls); hdrPort = 2'(port);
    @(negedge clk);
    hdrValid = 0;
    if (mUsed[e] < mLim[e]) begin mUsed[e]++; expA = 1; expS = 0; end
    else if (mUsed[7] < mLim[7]) begin mUsed[7]++; expA = 1; expS = 1; end
    else begin expA = 0; expS = 0; if (mDrop[cls] < DMAX) mDrop[cls]++; end
    check({req, " decValid"}, int'(decValid), 1);
    check({req, " decAdmit"}, int'(decAdmit), expA);
    check({req, " decShared"}, int'(decShared), expS);
  endtask

  task automatic rel(input int cls, input int port, input bit sh);
    int e = sh ? 7 : entOf(cls, port);
    relValid = 1; relClass = 2'(cls); relPort = 2'(port); relShared = sh;
    @(negedge clk);
    relValid = 0;
    if (mUsed[e] > 0) mUsed[e]--;
  endtask

  task automatic cfg(input int idx, input int lim);
    cfgWe = 1; cfgIdx = 3'(idx); cfgLimit = CW'(lim);
    @(negedge clk);
    cfgWe = 0;
    mLim[idx] = lim;
  endtask

  task automatic chkDrop(input string req, input int cls);
    dropSel = 2'(cls);
    #1;
    check(req, int'(dropCount), mDrop[cls]);
  endtask

  task automatic t_reset;   // R9
    check("R9 decValid", int'(decValid), 0);
    for (int c = 0; c < 4; c++) chkDrop("R9 dropCount", c);
  endtask

  task automatic t_spill;   // R3 R4 R8
    hdr("R3 private", 1, 0);
    hdr("R3 private", 1, 0);
    hdr("R4 shared", 1, 0);
    hdr("R4 shared", 1, 0);
    hdr("R4 drop", 1, 0);
    chkDrop("R8 drop count", 1);
  endtask

  task automatic t_flood;   // R1 R6
    hdr("R1 flood port0", 0, 0);
    hdr("R1 flood port0", 0, 0);
    hdr("R6 port0 exhausted", 0, 0);
    hdr("R6 port1 unaffected", 0, 1);
    hdr("R6 port1 unaffected", 0, 1);
    hdr("R1 mgmt class own quota", 3, 2);
    chkDrop("R8 flood drops", 0);
  endtask

  task automatic t_release; // R5
    rel(0, 0, 1);
    hdr("R5 shared freed", 1, 0);
    rel(2, 0, 0);   // class 2 counter is zero: ignored
    hdr("R5 class2 first", 2, 0);
    hdr("R5 class2 second", 2, 0);
    hdr("R5 zero release ignored", 2, 0);
    rel(0, 0, 0);
    hdr("R5 port0 freed", 0, 0);
  endtask

  task automatic t_limit;   // R7
    cfg(1, 1);
    rel(2, 3, 0);
    hdr("R7 lowered limit blocks", 2, 1);
    rel(2, 3, 0);
    hdr("R7 admits once below", 2, 1);
    cfg(1, 3);
    hdr("R7 raised limit", 2, 1);
    cfg(7, 4);
    hdr("R7 shared raised", 1, 0);
  endtask

  task automatic t_idle;    // R2
    @(negedge clk);
    check("R2 idle decValid", int'(decValid), 0);
  endtask

  task automatic t_sat;     // R8
    for (int i = 0; i < 22; i++) hdr("R8 mgmt flood", 3, 0);
    chkDrop("R8 saturation", 3);
    check("R8 saturated value", int'(dropCount), DMAX);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mUsed[i] = 0; mLim[i] = DL; end
    for (int i = 0; i < 4; i++) mDrop[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_spill();
    t_flood();
    t_release();
    t_idle();
    t_limit();
    t_sat();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule